// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the bus-facing half of a serially controlled peripheral on a two-wire open-drain bus. It oversamples the clock line and the data line with the system clock and cleans them up. It finds the frame delimiters and moves bytes in and out most significant bit first. The only thing it ever does to the data line is pull it low.

Each transaction opens with a single address byte. This byte carries no direction bit. Its upper nibble is a fixed device type and its lower nibble must equal four pin-strapped inputs. After the address, the block acknowledges a command byte and at most one data byte, and hands each of them to a command engine.

For a read, the engine raises `txEnable` and the block shifts out bytes from `txData`, for as long as the master acknowledges them. While the engine reports a slow internal write through `busy`, the address is left unacknowledged. A master can therefore poll until the write completes.

Top module: `serial_slave_front`

## Requirements
- R1: Out of reset the block releases the data line (`sdaDriveLow`=0), and `rxValid` and `stopSeen` are low.
- R2: A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. All clocking and data before the first START is ignored: nothing is acknowledged and nothing is presented.
- R3: The first byte after a START is acknowledged, by holding the data line low through the ninth clock, only if its upper nibble is 0101 and its lower nibble equals `devPins`. On any mismatch the block stays silent and ignores everything until the next START.
- R4: While `busy` is high at the end of the address byte, a matching address is not acknowledged. The same address is acknowledged again once `busy` is low.
- R5: After a matching address, the command byte is acknowledged and presented with a one-cycle `rxValid` and `rxIsCmd`=1. The byte after it is acknowledged and presented with `rxIsCmd`=0.
- R6: Any further written byte in the same transaction is neither acknowledged nor presented.
- R7: Received bytes are assembled most significant bit first, so `rxData` equals the byte as sent on the bus.
- R8: If `txEnable` is high when the acknowledge clock of the command byte or of a later byte ends, the block loads `txData`, pulses `txNext` and drives the byte most significant bit first. A bit of value 0 is driven as low and a bit of value 1 as released. The drive changes only while the clock line is low, and the line is released after eight bits.
- R9: A master acknowledge (data line low at the ninth clock of a read byte) loads and sends the next `txData`. A master non-acknowledge leaves the line released until the next START.
- R10: A STOP that ends a transaction with an acknowledged address gives a one-cycle `stopSeen`. A STOP after an unmatched address gives none.
- R11: A START or STOP seen inside a byte abandons that byte and does not present it. After a START the next byte is treated as an address.
- R12: `rxValid` and `stopSeen` are never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Level of the bus clock line |
| sdaIn | input | 1 | Level of the bus data line |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |
| devPins | input | 4 | Pin-strapped low nibble of the address |
| busy | input | 1 | Internal slow write in progress; address is refused |
| rxData | output | 8 | Last presented received byte |
| rxValid | output | 1 | One-cycle strobe for a new received byte |
| rxIsCmd | output | 1 | Presented byte is the command byte |
| stopSeen | output | 1 | One-cycle strobe at STOP ending an addressed transaction |
| txEnable | input | 1 | Engine requests a read after the current acknowledge |
| txData | input | 8 | Byte to send on the next load |
| txNext | output | 1 | One-cycle strobe when `txData` has been loaded |

## Verification
Properties watch the cycle-level rules on every cycle. The pulse strobes are checked to be one cycle wide. A presented byte is checked to coincide with an acknowledge drive. Any START or STOP is checked to release the data line. A drive change or a transmit load is checked to happen only while the clock line is low. Address matching and refusal while busy, the command and data byte limit, bit order, read continuation on master acknowledge and abort inside a byte all depend on whole bus transactions. Only the directed bus scenarios can show those.

// File: rtl/sslv_pkg.sv
package sslv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_WAIT
  } slvState_t;

  // Byte position inside a transaction: 0 address, 1 command, 2 data, 3 beyond
  localparam int BYTE_IDX_W = 2;

  typedef struct packed {
    logic                  sclRise;
    logic                  sclFall;
    logic                  start;
    logic                  stop;
    logic                  sdaBit;
    logic                  byteDone;
    logic                  lastTx;
    logic                  addrMatch;
    logic [BYTE_IDX_W-1:0] byteIdx;
  } busEvt_t;

  typedef struct packed {
    logic clrBit;
    logic shiftIn;
    logic incByte;
    logic clrByte;
    logic loadTx;
    logic shiftOut;
    logic driveAck;
    logic driveData;
    logic rxStrobe;
    logic stopStrobe;
  } dpCtl_t;

endpackage

// File: rtl/sslv_filter.sv
module sslv_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);

  localparam int HALF = FILT_LEN / 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_LEN-1:0]    winQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      winQ    <= '1;
      filtOut <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], rawIn};
      winQ    <= {winQ[FILT_LEN-2:0], syncQ[SYNC_STAGES-1]};
      filtOut <= ($countones(winQ) > HALF);
    end
  end

endmodule

// File: rtl/sslv_datapath.sv
module sslv_datapath
  import sslv_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         PIN_W       = 4,
  parameter logic [3:0] TYPE_ID     = 4'b0101,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [PIN_W-1:0]  devPins,
  input  logic [DATA_W-1:0] txData,
  input  dpCtl_t            ctl,
  output busEvt_t           evt,
  output logic              sdaDriveLow,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxIsCmd,
  output logic              stopSeen,
  output logic              txNext
);

  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int TYPE_W = DATA_W - PIN_W;
  localparam int LINES  = 2;

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] filtLines;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : gLine
    sslv_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) filt_i (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawLines[g]),
      .filtOut(filtLines[g])
    );
  end

  logic sclNow, sdaNow, sclPrev, sdaPrev;
  assign sclNow = filtLines[1];
  assign sdaNow = filtLines[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  logic [CNT_W-1:0]      bitCnt;
  logic [BYTE_IDX_W-1:0] byteIdx;
  logic [DATA_W-1:0]     rxShift;
  logic [DATA_W-1:0]     txShift;

  always_comb begin
    evt           = '0;
    evt.sclRise   = sclNow & ~sclPrev;
    evt.sclFall   = ~sclNow & sclPrev;
    evt.start     = sclNow & sclPrev & sdaPrev & ~sdaNow;
    evt.stop      = sclNow & sclPrev & ~sdaPrev & sdaNow;
    evt.sdaBit    = sdaNow;
    evt.byteDone  = (bitCnt == CNT_W'(DATA_W));
    evt.lastTx    = (bitCnt == CNT_W'(DATA_W - 1));
    evt.addrMatch = (rxShift[DATA_W-1 -: TYPE_W] == TYPE_ID[TYPE_W-1:0]) &&
                    (rxShift[PIN_W-1:0] == devPins);
    evt.byteIdx   = byteIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteIdx <= '0;
      rxShift <= '0;
      txShift <= '1;
    end else begin
      if (ctl.clrBit || ctl.loadTx) begin
        bitCnt <= '0;
      end else if (ctl.shiftIn || ctl.shiftOut) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (ctl.shiftIn) begin
        rxShift <= {rxShift[DATA_W-2:0], sdaNow};
      end
      if (ctl.loadTx) begin
        txShift <= txData;
      end else if (ctl.shiftOut) begin
        txShift <= {txShift[DATA_W-2:0], 1'b1};
      end
      if (ctl.clrByte) begin
        byteIdx <= '0;
      end else if (ctl.incByte && (byteIdx != '1)) begin
        byteIdx <= byteIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      rxValid  <= 1'b0;
      rxIsCmd  <= 1'b0;
      stopSeen <= 1'b0;
      txNext   <= 1'b0;
    end else begin
      rxValid  <= ctl.rxStrobe;
      stopSeen <= ctl.stopStrobe;
      txNext   <= ctl.loadTx;
      if (ctl.rxStrobe) begin
        rxData  <= rxShift;
        rxIsCmd <= (byteIdx == BYTE_IDX_W'(1));
      end
    end
  end

  assign sdaDriveLow = ctl.driveAck | (ctl.driveData & ~txShift[DATA_W-1]);

endmodule

// File: rtl/sslv_ctrl.sv
module sslv_ctrl
  import sslv_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t evt,
  input  logic    busy,
  input  logic    txEnable,
  output dpCtl_t  ctl
);

  slvState_t state, nextState;
  logic      addressed, setAddr;

  always_comb begin
    ctl           = '0;
    nextState     = state;
    setAddr       = 1'b0;
    ctl.driveAck  = (state == ST_ACK);
    ctl.driveData = (state == ST_SEND);

    if (evt.stop) begin
      nextState      = ST_IDLE;
      ctl.clrBit     = 1'b1;
      ctl.stopStrobe = addressed;
    end else if (evt.start) begin
      nextState   = ST_RECV;
      ctl.clrBit  = 1'b1;
      ctl.clrByte = 1'b1;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (evt.sclRise) begin
            ctl.shiftIn = 1'b1;
          end else if (evt.sclFall && evt.byteDone) begin
            if (evt.byteIdx == '0) begin
              if (evt.addrMatch && !busy) begin
                nextState = ST_ACK;
                setAddr   = 1'b1;
              end else begin
                nextState = ST_WAIT;
              end
            end else if (evt.byteIdx != '1) begin
              nextState    = ST_ACK;
              ctl.rxStrobe = 1'b1;
            end else begin
              nextState = ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (evt.sclFall) begin
            ctl.incByte = 1'b1;
            if ((evt.byteIdx != '0) && txEnable) begin
              ctl.loadTx = 1'b1;
              nextState  = ST_SEND;
            end else begin
              ctl.clrBit = 1'b1;
              nextState  = ST_RECV;
            end
          end
        end
        ST_SEND: begin
          if (evt.sclFall) begin
            if (evt.lastTx) begin
              nextState = ST_MACK;
            end else begin
              ctl.shiftOut = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (evt.sclRise && evt.sdaBit) begin
            nextState = ST_WAIT;
          end else if (evt.sclFall) begin
            ctl.loadTx = 1'b1;
            nextState  = ST_SEND;
          end
        end
        default: begin
          nextState = state;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      addressed <= 1'b0;
    end else begin
      state <= nextState;
      if (evt.start || evt.stop) begin
        addressed <= 1'b0;
      end else if (setAddr) begin
        addressed <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_slave_front.sv
module serial_slave_front
  import sslv_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         PIN_W       = 4,
  parameter logic [3:0] TYPE_ID     = 4'b0101,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [PIN_W-1:0]  devPins,
  input  logic              busy,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxIsCmd,
  output logic              stopSeen,
  input  logic              txEnable,
  input  logic [DATA_W-1:0] txData,
  output logic              txNext
);

  busEvt_t evt;
  dpCtl_t  ctl;

  sslv_datapath #(
    .DATA_W     (DATA_W),
    .PIN_W      (PIN_W),
    .TYPE_ID    (TYPE_ID),
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .devPins    (devPins),
    .txData     (txData),
    .ctl        (ctl),
    .evt        (evt),
    .sdaDriveLow(sdaDriveLow),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .rxIsCmd    (rxIsCmd),
    .stopSeen   (stopSeen),
    .txNext     (txNext)
  );

  sslv_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .busy    (busy),
    .txEnable(txEnable),
    .ctl     (ctl)
  );

endmodule

// File: rtl/sslv_checker.sv
module sslv_checker
  import sslv_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sclIn,
  input logic    sdaDriveLow,
  input logic    rxValid,
  input logic    stopSeen,
  input logic    txNext,
  input busEvt_t evt
);

  // R12
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R12
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !stopSeen);

  // R5
  rx_acked_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> sdaDriveLow);

  // R11
  abort_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt.start || evt.stop) |=> !sdaDriveLow);

  // R8
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaDriveLow) && !$past(evt.start) && !$past(evt.stop)) |-> !sclIn);

  // R8
  load_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    txNext |-> !sclIn);

endmodule

bind serial_slave_front sslv_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaDriveLow(sdaDriveLow),
  .rxValid    (rxValid),
  .stopSeen   (stopSeen),
  .txNext     (txNext),
  .evt        (evt)
);

// File: tb/serial_slave_front_tb.sv
module serial_slave_front_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  Q          = 10;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaBus;
  logic       sdaDriveLow;
  logic [3:0] devPins = 4'hA;
  logic       busy = 1'b0;
  logic [7:0] rxData;
  logic       rxValid, rxIsCmd, stopSeen, txNext;
  logic       txEnable = 1'b0;
  logic [7:0] txData = 8'h00;

  int checks = 0;
  int fails  = 0;
  int rxCnt = 0, stopCnt = 0, txCnt = 0;
  logic [7:0] lastRx = 8'h00;
  logic       lastCmd = 1'b0;
  logic       prevRx = 1'b0, prevStop = 1'b0;
  logic       wideStrobe = 1'b0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sdaBus = sdaM & ~sdaDriveLow;

  serial_slave_front dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaBus),
    .sdaDriveLow(sdaDriveLow),
    .devPins    (devPins),
    .busy       (busy),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .rxIsCmd    (rxIsCmd),
    .stopSeen   (stopSeen),
    .txEnable   (txEnable),
    .txData     (txData),
    .txNext     (txNext)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      rxCnt   <= rxCnt + 1;
      lastRx  <= rxData;
      lastCmd <= rxIsCmd;
    end
    if (stopSeen) stopCnt <= stopCnt + 1;
    if (txNext) txCnt <= txCnt + 1;
    if ((rxValid && prevRx) || (stopSeen && prevStop)) wideStrobe <= 1'b1;
    prevRx   <= rxValid;
    prevStop <= stopSeen;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
    waitQ();
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaM = b;    waitQ();
    sclM = 1'b1; waitQ();
    seen = sdaBus; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = ~s;
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
    clockBit(~mAck, s);
  endtask

  task automatic testReset();
    check(sdaDriveLow == 1'b0, "R1 drive", sdaDriveLow, 0);
    check(rxValid == 1'b0, "R1 rxValid", rxValid, 0);
    check(stopSeen == 1'b0, "R1 stopSeen", stopSeen, 0);
  endtask

  task automatic testNoStart();
    logic a;
    int r0 = rxCnt;
    sclM = 1'b0; waitQ();
    writeByte(8'h5A, a);
    writeByte(8'h9C, a);
    check(a == 1'b0, "R2 no ack before START", a, 0);
    check(rxCnt == r0, "R2 nothing presented", rxCnt, r0);
  endtask

  task automatic testWrite();
    logic a;
    int r0, s0;
    r0 = rxCnt; s0 = stopCnt;
    busStart();
    writeByte(8'h5A, a);
    check(a == 1'b1, "R3 address ack", a, 1);
    writeByte(8'h9C, a);
    check(a == 1'b1, "R5 command ack", a, 1);
    check(rxCnt == r0 + 1, "R5 command presented", rxCnt, r0 + 1);
    check(lastRx == 8'h9C, "R7 command value", lastRx, 8'h9C);
    check(lastCmd == 1'b1, "R5 command flag", lastCmd, 1);
    writeByte(8'h2B, a);
    check(a == 1'b1, "R5 data ack", a, 1);
    check(lastRx == 8'h2B && lastCmd == 1'b0, "R7 data value", {lastCmd, lastRx}, 9'h02B);
    writeByte(8'h77, a);
    check(a == 1'b0, "R6 extra byte no ack", a, 0);
    check(rxCnt == r0 + 2, "R6 extra byte not presented", rxCnt, r0 + 2);
    busStop();
    check(stopCnt == s0 + 1, "R10 stop after addressed", stopCnt, s0 + 1);
  endtask

  task automatic testWrongAddr();
    logic a;
    int r0, s0;
    r0 = rxCnt; s0 = stopCnt;
    busStart();
    writeByte(8'h5B, a);
    check(a == 1'b0, "R3 pin mismatch nak", a, 0);
    writeByte(8'h9C, a);
    check(a == 1'b0 && rxCnt == r0, "R3 ignored after mismatch", rxCnt, r0);
    busStop();
    check(stopCnt == s0, "R10 no stop strobe unaddressed", stopCnt, s0);
    busStart();
    writeByte(8'h6A, a);
    check(a == 1'b0, "R3 type mismatch nak", a, 0);
    busStop();
  endtask

  task automatic testBusy();
    logic a;
    busy = 1'b1;
    busStart();
    writeByte(8'h5A, a);
    check(a == 1'b0, "R4 nak while busy", a, 0);
    busStop();
    busy = 1'b0;
    busStart();
    writeByte(8'h5A, a);
    check(a == 1'b1, "R4 ack after busy", a, 1);
    busStop();
  endtask

  task automatic testRead();
    logic a, s;
    logic [7:0] b;
    int t0 = txCnt;
    busStart();
    writeByte(8'h5A, a);
    txEnable = 1'b1;
    txData = 8'hA5;
    writeByte(8'h9A, a);
    check(a == 1'b1, "R8 command ack before read", a, 1);
    txData = 8'h3C;
    readByte(1'b1, b);
    check(b == 8'hA5, "R8 first read byte", b, 8'hA5);
    readByte(1'b0, b);
    check(b == 8'h3C, "R9 byte after master ack", b, 8'h3C);
    check(txCnt == t0 + 2, "R8 load strobes", txCnt, t0 + 2);
    txData = 8'h00;
    clockBit(1'b1, s);
    check(s == 1'b1, "R9 released after master nak", s, 1);
    txEnable = 1'b0;
    busStop();
  endtask

  task automatic testAbort();
    logic a, s;
    int r0;
    busStart();
    writeByte(8'h5A, a);
    r0 = rxCnt;
    for (int i = 0; i < 4; i++) clockBit(1'b0, s);
    busStop();
    check(rxCnt == r0, "R11 stop inside byte drops it", rxCnt, r0);
    busStart();
    for (int i = 0; i < 3; i++) clockBit(1'b1, s);
    busStart();
    writeByte(8'h5A, a);
    check(a == 1'b1, "R11 address after repeated start", a, 1);
    writeByte(8'h11, a);
    check(a == 1'b1 && lastRx == 8'h11 && lastCmd == 1'b1, "R11 command after abort", lastRx, 8'h11);
    busStop();
    check(wideStrobe == 1'b0, "R12 strobes one cycle", wideStrobe, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testNoStart();
    testWrite();
    testWrongAddr();
    testBusy();
    testRead();
    testAbort();
    finishRun();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

endmodule